// File: doc/BRIEF.md
# Signed Add/Subtract Unit with Three-Way Compare

This is a combinational arithmetic unit for two operands of parameterised width in two's complement form. An operation select picks one of three modes. Add returns A + B. Subtract returns A - B. Compare works out A - B but does not return the result. Instead it reports how the operands are ordered. In every mode the unit also reports a carry, a zero flag, a sign flag and a signed-overflow flag.

One ripple adder serves all three modes. For subtraction the second operand is bit-inverted and the carry-in is set to 1. A parameter selects how signed overflow is formed. One variant XORs the carry entering the top bit with the carry leaving it. The other forms bit N of the operands sign-extended to N+1 bits and compares it with bit N-1. The two variants must give the same answer for every operand pair. In compare mode the unit reports "less than" as the XOR of the sign and overflow of the dummy difference. It also gives a 2-bit ordering code.

Top module: `sacmp_unit`

## Requirements
- R1: In add mode `sum_o` equals (A + B) mod 2^N, and `carry_o` is the bit that would sit at position N of the unsigned sum.
- R2: In subtract mode `sum_o` equals (A - B) mod 2^N, computed as A + ~B + 1. `carry_o` is 1 exactly when A >= B as unsigned values (no borrow).
- R3: `ovf_o` is 1 exactly when the true signed result of the add or subtract lies outside [-2^(N-1), 2^(N-1)-1]. For N=4, 7 + 3 gives 1010 with `ovf_o`=1, and 3 + (-1) gives 0010 with `ovf_o`=0.
- R4: `zero_o` is 1 when all N bits of the raw adder result are 0. `neg_o` equals bit N-1 of that raw result. This holds in compare mode too.
- R5: In compare mode `sum_o` is all zeros. `carry_o`, `zero_o`, `neg_o` and `ovf_o` are those of A - B.
- R6: In compare mode `lt_o` = `neg_o` XOR `ovf_o`, which is 1 exactly when signed A < signed B. Outside compare mode `lt_o` is 0.
- R7: In compare mode `ord_o` is 2'b01 when A > B, 2'b11 when A < B and 2'b00 when A = B (signed). The most negative value orders below every other value. Outside compare mode `ord_o` is 2'b00, and 2'b10 never appears.
- R8: The overflow variant picked by OVF_SIGN_EXT (0: carry-in XOR carry-out of the MSB, 1: sign-extended bit N vs bit N-1) does not change any output for any operand pair.
- R9: Op encoding: `op_i`[1]=1 selects compare and `op_i`[0] is then ignored (2'b11 gives the same outputs as 2'b10). Otherwise `op_i`[0]=1 selects subtract and 0 selects add.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A, two's complement |
| b_i | input | WIDTH | Operand B, two's complement |
| op_i | input | 2 | Operation select (see R9) |
| sum_o | output | WIDTH | Sum or difference; zero in compare mode |
| carry_o | output | 1 | Carry out of bit N-1 |
| zero_o | output | 1 | Raw result is zero |
| neg_o | output | 1 | MSB of raw result |
| ovf_o | output | 1 | Signed overflow |
| lt_o | output | 1 | Signed A < B (compare mode) |
| ord_o | output | 2 | Ordering code 01 / 11 / 00 (compare mode) |

## Verification
Directed 8-bit vectors cover several cases:
- operands of mixed sign, which separate correct carry handling from sign handling;
- pairs at the edges of the range (127 + 1, -128 - 1, -128 against 127), which show whether overflow is a true signed condition rather than a carry;
- equal operands, which exercise the zero flag and the 00 ordering code.

Two 4-bit instances, one built with each overflow variant, are swept over all 256 operand pairs in every op code. This shows that the two overflow rules agree, and that the compare result depends on the signed order and not on the unsigned one. Driving op code 11 after 10 with the same operands shows that the low select bit has no effect in compare mode.

// File: rtl/sacmp_pkg.sv
package sacmp_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_CMP  = 2'b10,
    OP_CMPX = 2'b11
  } op_e;

  localparam logic [1:0] ORD_EQ = 2'b00;
  localparam logic [1:0] ORD_GT = 2'b01;
  localparam logic [1:0] ORD_LT = 2'b11;
endpackage

// File: rtl/sacmp_operand.sv
module sacmp_operand #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] b_eff_o,
  output logic             cin_o,
  output logic             is_cmp_o
);
  logic do_sub;

  // compare always subtracts; op_i[0] only matters outside compare
  assign do_sub   = op_i[1] | op_i[0];
  assign is_cmp_o = op_i[1];
  assign b_eff_o  = do_sub ? ~b_i : b_i;
  assign cin_o    = do_sub;
endmodule

// File: rtl/sacmp_adder.sv
module sacmp_adder #(
  parameter int unsigned WIDTH        = 8,
  parameter bit          OVF_SIGN_EXT = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0] c_vec;

  always_comb begin
    c_vec[0] = cin_i;
    for (int i = 0; i < WIDTH; i++) begin
      sum_o[i]   = a_i[i] ^ b_i[i] ^ c_vec[i];
      c_vec[i+1] = (a_i[i] & b_i[i]) | (c_vec[i] & (a_i[i] ^ b_i[i]));
    end
  end

  assign cout_o = c_vec[WIDTH];

  generate
    if (OVF_SIGN_EXT) begin : g_ovf_ext
      logic ext_top;
      // bit N of the sum of both operands sign-extended to N+1 bits
      assign ext_top = a_i[MSB] ^ b_i[MSB] ^ c_vec[WIDTH];
      assign ovf_o   = ext_top ^ sum_o[MSB];
    end else begin : g_ovf_carry
      assign ovf_o = c_vec[MSB] ^ c_vec[WIDTH];
    end
  endgenerate
endmodule

// File: rtl/sacmp_flags.sv
module sacmp_flags
  import sacmp_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] raw_i,
  input  logic             ovf_i,
  input  logic             is_cmp_i,
  output logic             zero_o,
  output logic             neg_o,
  output logic             lt_o,
  output logic [1:0]       ord_o
);
  logic lt_raw;

  assign zero_o = (raw_i == '0);
  assign neg_o  = raw_i[WIDTH-1];
  assign lt_raw = neg_o ^ ovf_i;
  assign lt_o   = is_cmp_i & lt_raw;

  always_comb begin
    if (!is_cmp_i || zero_o) ord_o = ORD_EQ;
    else if (lt_raw)         ord_o = ORD_LT;
    else                     ord_o = ORD_GT;
  end
endmodule

// File: rtl/sacmp_unit.sv
module sacmp_unit
  import sacmp_pkg::*;
#(
  parameter int unsigned WIDTH        = 8,
  parameter bit          OVF_SIGN_EXT = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             ovf_o,
  output logic             lt_o,
  output logic [1:0]       ord_o
);
  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic             is_cmp;
  logic [WIDTH-1:0] raw;

  sacmp_operand #(.WIDTH(WIDTH)) u_operand (
    .b_i      (b_i),
    .op_i     (op_i),
    .b_eff_o  (b_eff),
    .cin_o    (cin),
    .is_cmp_o (is_cmp)
  );

  sacmp_adder #(.WIDTH(WIDTH), .OVF_SIGN_EXT(OVF_SIGN_EXT)) u_adder (
    .a_i    (a_i),
    .b_i    (b_eff),
    .cin_i  (cin),
    .sum_o  (raw),
    .cout_o (carry_o),
    .ovf_o  (ovf_o)
  );

  sacmp_flags #(.WIDTH(WIDTH)) u_flags (
    .raw_i    (raw),
    .ovf_i    (ovf_o),
    .is_cmp_i (is_cmp),
    .zero_o   (zero_o),
    .neg_o    (neg_o),
    .lt_o     (lt_o),
    .ord_o    (ord_o)
  );

  assign sum_o = is_cmp ? '0 : raw;
endmodule

// File: rtl/sacmp_unit_chk.sv
module sacmp_unit_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       op_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o,
  input logic             zero_o,
  input logic             neg_o,
  input logic             ovf_o,
  input logic             lt_o,
  input logic [1:0]       ord_o
);
  localparam int unsigned XW = WIDTH + 2;
  localparam logic signed [XW-1:0] MAXV = {3'b000, {(WIDTH-1){1'b1}}};
  localparam logic signed [XW-1:0] MINV = {3'b111, {(WIDTH-1){1'b0}}};

  logic                 is_cmp, is_sub, ucarry, range_ovf;
  logic signed [XW-1:0] ax, bx, exact;

  always_comb begin
    is_cmp    = op_i[1];
    is_sub    = op_i[1] | op_i[0];
    ax        = {{2{a_i[WIDTH-1]}}, a_i};
    bx        = {{2{b_i[WIDTH-1]}}, b_i};
    exact     = is_sub ? (ax - bx) : (ax + bx);
    range_ovf = (exact > MAXV) || (exact < MINV);
    ucarry    = ({1'b0, a_i} + {1'b0, b_i}) > {1'b0, {WIDTH{1'b1}}};
  end

  always_comb begin
    a_r1_add_carry: assert (is_sub || carry_o == ucarry)
      else $error("R1 carry mismatch");
    a_r2_sub_borrow: assert (!is_sub || carry_o == (a_i >= b_i))
      else $error("R2 borrow mismatch");
    a_r3_ovf_range: assert (ovf_o == range_ovf)
      else $error("R3 overflow mismatch");
    a_r4_cmp_eq_zero: assert (!is_cmp || zero_o == (a_i == b_i))
      else $error("R4 zero mismatch");
    a_r4_neg_msb: assert (is_cmp || neg_o == sum_o[WIDTH-1])
      else $error("R4 sign mismatch");
    a_r5_cmp_sum_zero: assert (!is_cmp || sum_o == '0)
      else $error("R5 sum not cleared");
    a_r6_lt_signed: assert (lt_o == (is_cmp && (ax < bx)))
      else $error("R6 less-than mismatch");
    a_r7_ord_legal: assert (ord_o != 2'b10)
      else $error("R7 illegal ordering code");
    a_r7_ord_lt: assert (!is_cmp || ((ord_o == 2'b11) == lt_o))
      else $error("R7 ordering disagrees with less-than");
    a_r7_ord_idle: assert (is_cmp || ord_o == 2'b00)
      else $error("R7 ordering set outside compare");
  end
endmodule

bind sacmp_unit sacmp_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .op_i    (op_i),
  .sum_o   (sum_o),
  .carry_o (carry_o),
  .zero_o  (zero_o),
  .neg_o   (neg_o),
  .ovf_o   (ovf_o),
  .lt_o    (lt_o),
  .ord_o   (ord_o)
);

// File: tb/sacmp_unit_tb_top.sv
`timescale 1ns/1ps
module sacmp_unit_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [7:0] a8 = '0, b8 = '0;
  logic [1:0] op8 = '0;
  logic [7:0] s8;
  logic       c8, z8, n8, v8, l8;
  logic [1:0] o8;

  logic [3:0] a4 = '0, b4 = '0;
  logic [1:0] op4 = '0;
  logic [3:0] s4c, s4s;
  logic       c4c, z4c, n4c, v4c, l4c, c4s, z4s, n4s, v4s, l4s;
  logic [1:0] o4c, o4s;

  sacmp_unit #(.WIDTH(8), .OVF_SIGN_EXT(1'b0)) dut_i (
    .a_i(a8), .b_i(b8), .op_i(op8), .sum_o(s8), .carry_o(c8), .zero_o(z8),
    .neg_o(n8), .ovf_o(v8), .lt_o(l8), .ord_o(o8));

  sacmp_unit #(.WIDTH(4), .OVF_SIGN_EXT(1'b0)) dut4c_i (
    .a_i(a4), .b_i(b4), .op_i(op4), .sum_o(s4c), .carry_o(c4c), .zero_o(z4c),
    .neg_o(n4c), .ovf_o(v4c), .lt_o(l4c), .ord_o(o4c));

  sacmp_unit #(.WIDTH(4), .OVF_SIGN_EXT(1'b1)) dut4s_i (
    .a_i(a4), .b_i(b4), .op_i(op4), .sum_o(s4s), .carry_o(c4s), .zero_o(z4s),
    .neg_o(n4s), .ovf_o(v4s), .lt_o(l4s), .ord_o(o4s));

  // reference from the requirements: packed {sum, carry, zero, neg, ovf, lt, ord}
  function automatic int model(int w, int ua, int ub, int op);
    int mask = (1 << w) - 1;
    int half = 1 << (w - 1);
    int sa   = (ua >= half) ? ua - (1 << w) : ua;
    int sb   = (ub >= half) ? ub - (1 << w) : ub;
    bit sub  = (op != 0);
    bit cmp  = (op >= 2);
    int raw, sv, r, ord;
    bit carry, zero, neg, ovf, lt;
    if (sub) begin raw = ua + ((~ub) & mask) + 1; sv = sa - sb; end
    else     begin raw = ua + ub;                 sv = sa + sb; end
    r     = raw & mask;
    carry = ((raw >> w) & 1) != 0;
    ovf   = (sv > half - 1) || (sv < -half);
    zero  = (r == 0);
    neg   = ((r >> (w - 1)) & 1) != 0;
    lt    = cmp && (sa < sb);
    ord   = !cmp ? 0 : (sa > sb) ? 1 : (sa < sb) ? 3 : 0;
    if (cmp) r = 0;
    return (r << 7) | (int'(carry) << 6) | (int'(zero) << 5) | (int'(neg) << 4)
         | (int'(ovf) << 3) | (int'(lt) << 2) | ord;
  endfunction

  task automatic compare(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive8(int a, int b, int op);
    @(negedge clk);
    a8 = 8'(a); b8 = 8'(b); op8 = 2'(op);
    @(posedge clk); #1;
  endtask

  function automatic int pack8();
    return (int'(s8) << 7) | (int'(c8) << 6) | (int'(z8) << 5) | (int'(n8) << 4)
         | (int'(v8) << 3) | (int'(l8) << 2) | int'(o8);
  endfunction

  task automatic chk8(string tag, int a, int b, int op);
    drive8(a, b, op);
    compare(tag, pack8(), model(8, a & 255, b & 255, op));
  endtask

  task automatic t_idle();
    chk8("R1 idle zero inputs", 0, 0, 0);
    compare("R4 idle zero flag", int'(z8), 1);
  endtask

  task automatic t_add();
    chk8("R1 add mixed sign", 15, -5, 0);
    chk8("R1 add carry out", 200, 100, 0);
    chk8("R1 add neg result", 5, -15, 0);
    chk8("R3 add pos overflow", 127, 1, 0);
    chk8("R3 add neg overflow", -128, -1, 0);
    chk8("R4 add to zero", 77, -77, 0);
  endtask

  task automatic t_sub();
    chk8("R2 sub neg operand", 15, -5, 1);
    chk8("R2 sub borrow", 15, 35, 1);
    chk8("R2 sub zero operand", 0, 0, 1);
    chk8("R3 sub neg overflow", -128, 1, 1);
    chk8("R3 sub pos overflow", 127, -1, 1);
    chk8("R3 sub of min", 0, -128, 1);
  endtask

  task automatic t_cmp();
    chk8("R5 cmp greater", 20, 3, 2);
    compare("R7 cmp greater code", int'(o8), 1);
    chk8("R6 cmp less", -7, 4, 2);
    compare("R6 cmp less flag", int'(l8), 1);
    chk8("R7 cmp equal", -50, -50, 2);
    compare("R7 cmp equal code", int'(o8), 0);
    chk8("R7 cmp min vs max", -128, 127, 2);
    compare("R7 min orders lowest", int'(o8), 3);
    chk8("R7 cmp max vs min", 127, -128, 2);
    compare("R6 overflowed diff not less", int'(l8), 0);
    chk8("R6 unsigned-larger but negative", 255, 1, 2);
  endtask

  task automatic t_op_alias();
    int ref_out;
    drive8(-3, 9, 2);
    ref_out = pack8();
    drive8(-3, 9, 3);
    compare("R9 op 11 same as 10", pack8(), ref_out);
    chk8("R9 op 11 vs model", 100, -100, 3);
  endtask

  task automatic t_ovf_examples();
    @(negedge clk); a4 = 4'd7; b4 = 4'd3; op4 = 2'b00; @(posedge clk); #1;
    compare("R3 4-bit 7+3 result", int'(s4c), 4'b1010);
    compare("R3 4-bit 7+3 overflow", int'(v4c), 1);
    @(negedge clk); a4 = 4'd3; b4 = 4'hF; op4 = 2'b00; @(posedge clk); #1;
    compare("R3 4-bit 3+(-1) result", int'(s4c), 4'b0010);
    compare("R3 4-bit 3+(-1) no overflow", int'(v4c), 0);
  endtask

  task automatic t_sweep4();
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          int exp4, actc, acts;
          @(negedge clk); a4 = 4'(a); b4 = 4'(b); op4 = 2'(op);
          @(posedge clk); #1;
          exp4 = model(4, a, b, op);
          actc = (int'(s4c) << 7) | (int'(c4c) << 6) | (int'(z4c) << 5) | (int'(n4c) << 4)
               | (int'(v4c) << 3) | (int'(l4c) << 2) | int'(o4c);
          acts = (int'(s4s) << 7) | (int'(c4s) << 6) | (int'(z4s) << 5) | (int'(n4s) << 4)
               | (int'(v4s) << 3) | (int'(l4s) << 2) | int'(o4s);
          compare("R8 sweep carry-xor variant", actc, exp4);
          compare("R8 sweep sign-ext variant", acts, exp4);
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_idle();
    t_add();
    t_sub();
    t_cmp();
    t_op_alias();
    t_ovf_examples();
    t_sweep4();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule